// File: doc/BRIEF.md
# Register-Mapped Byte Transfer Controller

This block sits between a host and one byte-wide device port. The host sees four 32-bit registers on a simple single-cycle register bus. It places a byte in the outbound data register, chooses a direction in the command register and raises the command-ready flag. The controller then raises busy, moves one byte across a valid/ready device port and drops command-ready, busy and error together. The host may poll busy in the status register or enable a one-cycle completion interrupt.

A read command pulls one byte from the device into the inbound data register and raises data-ready. A host read of that register consumes the byte. A transfer that the device does not finish within a programmable number of cycles leaves the block in a latched error state. Busy stays high until the host writes the error-clear bit.

Top module: `devCtrl`

## Requirements
- R1: Byte offsets 0x00 (inbound data, bits 7:0), 0x04 (outbound data, bits 7:0), 0x08 (status) and 0x0C (command) are mapped. Every other offset reads zero. All registers read zero after reset.
- R2: Status bit 0 is busy, bit 1 is data-ready and bit 2 is error. All other status bits read zero.
- R3: Command bits: bit 0 command-ready, bit 1 direction (1 = host to device, 0 = device to host), bit 2 interrupt enable, bit 3 error-clear (write-only, reads 0), bits 31:16 timeout. A command write is taken only while busy and command-ready are both clear, otherwise it is ignored. An outbound data write is ignored under the same condition.
- R4: One cycle after command-ready is accepted, busy reads 1. The device port is driven only while busy is 1.
- R5: A host-to-device command holds devOutValid high with the outbound byte on devOutData until devOutReady is sampled high.
- R6: On the clock edge that completes a transfer, busy, command-ready and error all fall together.
- R7: A device-to-host command raises devInReady. The byte on devInData is captured on the edge where devInValid is sampled, and data-ready is set.
- R8: A host read of offset 0x00 returns the captured byte and clears data-ready at that clock edge.
- R9: With a nonzero timeout T, if no handshake happens in T cycles of waiting, error is set, busy stays 1 and the port request drops. A timeout of 0 waits indefinitely.
- R10: In the error state, a command write with bit 3 set clears busy, error and command-ready at that edge.
- R11: When busy falls and interrupt enable is 1, irq is high for exactly the first cycle in which busy reads 0. Otherwise irq stays low.
- R12: Register read data is combinational from hostAddr during a read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostSel | input | 1 | Register access this cycle |
| hostWr | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 5 | Byte offset |
| hostWdata | input | 32 | Write data |
| hostRdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Completion pulse |
| devOutValid | output | 1 | Outbound byte valid |
| devOutData | output | 8 | Outbound byte |
| devOutReady | input | 1 | Device accepts outbound byte |
| devInReady | output | 1 | Controller wants an inbound byte |
| devInValid | input | 1 | Device offers inbound byte |
| devInData | input | 8 | Inbound byte |

## Verification
Say the command write lands on edge E0. Command-ready reads back right after E0, and busy plus the port request appear right after E1. Completion shows one cycle after the handshake edge, with irq high for just that cycle. A timeout of T raises error right after edge E(T+1) and not after E(T). The bench drives inputs on falling edges. It samples combinational register reads one nanosecond later without crossing an edge, and counts falling edges from each stimulus to the exact cycle where each result is due.

// File: rtl/devCtrlPkg.sv
`timescale 1ns/1ps
package devCtrlPkg;
  localparam int OFF_DIN  = 0;
  localparam int OFF_DOUT = 4;
  localparam int OFF_STAT = 8;
  localparam int OFF_CMD  = 12;

  localparam int CMD_GO     = 0;
  localparam int CMD_DIR    = 1;
  localparam int CMD_IRQEN  = 2;
  localparam int CMD_ERRCLR = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_ERR} ctlState_t;

  typedef struct packed {
    logic loadOut;
    logic captureIn;
    logic clearReady;
  } dpStrobe_t;
endpackage

// File: rtl/devCtrlControl.sv
`timescale 1ns/1ps
module devCtrlControl
  import devCtrlPkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int BUS_W  = 32,
  parameter int TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [BUS_W-1:0]  hostWdata,
  input  logic              devOutReady,
  input  logic              devInValid,
  output dpStrobe_t         strb,
  output logic              busy,
  output logic              error,
  output logic              cmdReady,
  output logic              cmdWrite,
  output logic              irqEn,
  output logic [TMO_W-1:0]  tmoLim,
  output logic              irq,
  output logic              devOutValid,
  output logic              devInReady
);
  localparam logic [ADDR_W-1:0] A_DIN  = ADDR_W'(OFF_DIN);
  localparam logic [ADDR_W-1:0] A_DOUT = ADDR_W'(OFF_DOUT);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFF_CMD);

  ctlState_t        state;
  logic [TMO_W-1:0] waitCnt;
  logic             wrCmd, wrDout, rdDin, acceptCmd, errClrHit, xferDone, tmoHit;
  logic             unusedBits;

  assign unusedBits = ^hostWdata[BUS_W-TMO_W-1:4];

  assign wrCmd     = hostSel && hostWr && (hostAddr == A_CMD);
  assign wrDout    = hostSel && hostWr && (hostAddr == A_DOUT);
  assign rdDin     = hostSel && !hostWr && (hostAddr == A_DIN);
  assign acceptCmd = wrCmd && !busy && !cmdReady;
  assign errClrHit = wrCmd && hostWdata[CMD_ERRCLR] && (state == ST_ERR);

  assign devOutValid = (state == ST_XFER) && cmdWrite;
  assign devInReady  = (state == ST_XFER) && !cmdWrite;
  assign xferDone    = (devOutValid && devOutReady) || (devInReady && devInValid);
  assign tmoHit      = (tmoLim != '0) && (waitCnt == tmoLim - 1'b1);

  always_comb begin
    strb.loadOut    = wrDout && !busy && !cmdReady;
    strb.captureIn  = devInReady && devInValid;
    strb.clearReady = rdDin;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      busy     <= 1'b0;
      error    <= 1'b0;
      cmdReady <= 1'b0;
      cmdWrite <= 1'b0;
      irqEn    <= 1'b0;
      tmoLim   <= '0;
      waitCnt  <= '0;
      irq      <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (acceptCmd) begin
        cmdReady <= hostWdata[CMD_GO];
        cmdWrite <= hostWdata[CMD_DIR];
        irqEn    <= hostWdata[CMD_IRQEN];
        tmoLim   <= hostWdata[BUS_W-1 -: TMO_W];
      end
      case (state)
        ST_IDLE: begin
          if (cmdReady) begin
            busy    <= 1'b1;
            waitCnt <= '0;
            state   <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (xferDone) begin
            busy     <= 1'b0;
            cmdReady <= 1'b0;
            error    <= 1'b0;
            irq      <= irqEn;
            state    <= ST_IDLE;
          end else if (tmoHit) begin
            error <= 1'b1;
            state <= ST_ERR;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        ST_ERR: begin
          if (errClrHit) begin
            busy     <= 1'b0;
            cmdReady <= 1'b0;
            error    <= 1'b0;
            irq      <= irqEn;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_PORT_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (devOutValid || devInReady) |-> busy); // R4
  AST_BUSY_AFTER_GO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmdReady)); // R4
  AST_CLEAR_TOGETHER: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (!error && !cmdReady)); // R6
  AST_ERR_HOLDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    error |-> busy); // R9
  AST_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrCmd) |=> ($stable(cmdWrite) && $stable(tmoLim) && $stable(irqEn))); // R3
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq); // R11
  AST_IRQ_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $fell(busy)); // R11
endmodule

// File: rtl/devCtrlDatapath.sv
`timescale 1ns/1ps
module devCtrlDatapath
  import devCtrlPkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int BUS_W  = 32,
  parameter int DATA_W = 8,
  parameter int TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostByte,
  input  logic [DATA_W-1:0] devInData,
  input  logic              busy,
  input  logic              error,
  input  logic              cmdReady,
  input  logic              cmdWrite,
  input  logic              irqEn,
  input  logic [TMO_W-1:0]  tmoLim,
  output logic [DATA_W-1:0] devOutData,
  output logic [BUS_W-1:0]  hostRdata
);
  localparam logic [ADDR_W-1:0] A_DIN  = ADDR_W'(OFF_DIN);
  localparam logic [ADDR_W-1:0] A_DOUT = ADDR_W'(OFF_DOUT);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFF_CMD);

  logic [DATA_W-1:0] dataOut, dataIn;
  logic              dataReady;

  assign devOutData = dataOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut   <= '0;
      dataIn    <= '0;
      dataReady <= 1'b0;
    end else begin
      if (strb.loadOut) dataOut <= hostByte;
      if (strb.captureIn) begin
        dataIn    <= devInData;
        dataReady <= 1'b1;
      end else if (strb.clearReady) begin
        dataReady <= 1'b0;
      end
    end
  end

  always_comb begin
    hostRdata = '0;
    if (hostSel && !hostWr) begin
      case (hostAddr)
        A_DIN:  hostRdata[DATA_W-1:0] = dataIn;
        A_DOUT: hostRdata[DATA_W-1:0] = dataOut;
        A_STAT: hostRdata[2:0] = {error, dataReady, busy};
        A_CMD: begin
          hostRdata[CMD_GO]            = cmdReady;
          hostRdata[CMD_DIR]           = cmdWrite;
          hostRdata[CMD_IRQEN]         = irqEn;
          hostRdata[BUS_W-1 -: TMO_W]  = tmoLim;
        end
        default: hostRdata = '0;
      endcase
    end
  end

  AST_CAPTURE_SETS_READY: assert property (@(posedge clk) disable iff (!rstN)
    strb.captureIn |=> dataReady); // R7
  AST_DOUT_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (busy && hostSel && hostWr && hostAddr == A_DOUT) |=> $stable(dataOut)); // R3
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clearReady && !strb.captureIn) |=> !dataReady); // R8
endmodule

// File: rtl/devCtrl.sv
`timescale 1ns/1ps
module devCtrl
  import devCtrlPkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int BUS_W  = 32,
  parameter int DATA_W = 8,
  parameter int TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [BUS_W-1:0]  hostWdata,
  output logic [BUS_W-1:0]  hostRdata,
  output logic              irq,
  output logic              devOutValid,
  output logic [DATA_W-1:0] devOutData,
  input  logic              devOutReady,
  output logic              devInReady,
  input  logic              devInValid,
  input  logic [DATA_W-1:0] devInData
);
  dpStrobe_t        strb;
  logic             busy, error, cmdReady, cmdWrite, irqEn;
  logic [TMO_W-1:0] tmoLim;

  devCtrlControl #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .TMO_W(TMO_W)) u_ctl (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostWdata(hostWdata),
    .devOutReady(devOutReady), .devInValid(devInValid),
    .strb(strb), .busy(busy), .error(error), .cmdReady(cmdReady),
    .cmdWrite(cmdWrite), .irqEn(irqEn), .tmoLim(tmoLim), .irq(irq),
    .devOutValid(devOutValid), .devInReady(devInReady)
  );

  devCtrlDatapath #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .DATA_W(DATA_W), .TMO_W(TMO_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .hostSel(hostSel), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostByte(hostWdata[DATA_W-1:0]), .devInData(devInData),
    .busy(busy), .error(error), .cmdReady(cmdReady), .cmdWrite(cmdWrite),
    .irqEn(irqEn), .tmoLim(tmoLim), .devOutData(devOutData), .hostRdata(hostRdata)
  );
endmodule

// File: tb/devCtrl_bench.sv
`timescale 1ns/1ps
module devCtrl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostSel = 1'b0, hostWr = 1'b0;
  logic [4:0]  hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        irq, devOutValid, devInReady;
  logic [7:0]  devOutData;
  logic        devOutReady = 1'b0, devInValid = 1'b0;
  logic [7:0]  devInData = '0;
  int          checks = 0, failures = 0;
  bit          ended = 1'b0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  devCtrl u_devCtrl (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .irq(irq),
    .devOutValid(devOutValid), .devOutData(devOutData), .devOutReady(devOutReady),
    .devInReady(devInReady), .devInValid(devInValid), .devInData(devInData)
  );

  function automatic logic [31:0] expStat(bit b, bit r, bit e);
    return {29'd0, e, r, b};
  endfunction

  function automatic logic [31:0] cmdWord(logic [15:0] tmo, bit clr, bit ie, bit wr, bit go);
    return {tmo, 12'd0, clr, ie, wr, go};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    hostSel = 1'b1; hostWr = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostSel = 1'b0; hostWr = 1'b0;
  endtask

  task automatic peek(logic [4:0] a, output logic [31:0] d);
    hostSel = 1'b1; hostWr = 1'b0; hostAddr = a;
    #1 d = hostRdata;
    hostSel = 1'b0;
  endtask

  task automatic busRead(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    hostSel = 1'b1; hostWr = 1'b0; hostAddr = a;
    #1 d = hostRdata;
    @(negedge clk);
    hostSel = 1'b0;
  endtask

  bit expRdy = 1'b0;

  task automatic runXfer(bit isWr, logic [7:0] data, bit ie, int delay);
    if (isWr) busWrite(5'h04, {24'd0, data});
    busWrite(5'h0C, cmdWord(16'd200, 1'b0, ie, isWr, 1'b1));
    peek(5'h08, rv); chk("R4 busy not yet", rv, expStat(0, expRdy, 0));
    chk("R4 port idle before busy", {31'd0, devOutValid | devInReady}, 32'd0);
    @(negedge clk);
    peek(5'h08, rv); chk("R4 busy set", rv, expStat(1, expRdy, 0));
    if (isWr) begin
      chk("R5 valid", {31'd0, devOutValid}, 32'd1);
      chk("R5 data", {24'd0, devOutData}, {24'd0, data});
    end else chk("R7 inReady", {31'd0, devInReady}, 32'd1);
    for (int i = 0; i < delay; i++) @(negedge clk);
    if (isWr) devOutReady = 1'b1; else begin devInValid = 1'b1; devInData = data; end
    @(negedge clk);
    devOutReady = 1'b0; devInValid = 1'b0;
    if (!isWr) expRdy = 1'b1;
    peek(5'h08, rv); chk("R6 done status", rv, expStat(0, expRdy, 0));
    peek(5'h0C, rv); chk("R6 go cleared", {31'd0, rv[0]}, 32'd0);
    chk("R11 irq on fall", {31'd0, irq}, {31'd0, ie});
    @(negedge clk);
    chk("R11 irq one cycle", {31'd0, irq}, 32'd0);
    if (!isWr) begin
      busRead(5'h00, rv); chk("R8 data-in value", rv, {24'd0, data});
      expRdy = 1'b0;
      peek(5'h08, rv); chk("R8 ready cleared", rv, expStat(0, 0, 0));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state and map
    peek(5'h00, rv); chk("R1 din reset", rv, 0);
    peek(5'h04, rv); chk("R1 dout reset", rv, 0);
    peek(5'h08, rv); chk("R2 status reset", rv, 0);
    peek(5'h0C, rv); chk("R1 cmd reset", rv, 0);
    peek(5'h10, rv); chk("R1 unmapped 0x10", rv, 0);
    chk("R11 irq reset", {31'd0, irq}, 0);

    // R3 config write without go: fields load, no busy
    busWrite(5'h0C, cmdWord(16'h0033, 1'b0, 1'b1, 1'b1, 1'b0));
    peek(5'h0C, rv); chk("R3 fields loaded", rv, cmdWord(16'h0033, 0, 1, 1, 0));
    @(negedge clk);
    peek(5'h08, rv); chk("R3 no go no busy", rv, 0);

    // directed transfers
    runXfer(1'b1, 8'hA5, 1'b1, 0);
    runXfer(1'b1, 8'h3C, 1'b0, 3);
    runXfer(1'b0, 8'h5A, 1'b1, 2);
    runXfer(1'b0, 8'hC3, 1'b0, 0);

    // R3 data-out write while busy ignored
    busWrite(5'h04, 32'h11);
    busWrite(5'h0C, cmdWord(16'd0, 0, 0, 1, 1));
    @(negedge clk);
    busWrite(5'h04, 32'h99);
    chk("R3 dout frozen while busy", {24'd0, devOutData}, 32'h11);
    devOutReady = 1'b1; @(negedge clk); devOutReady = 1'b0;
    peek(5'h04, rv); chk("R3 dout reg kept", rv, 32'h11);

    // R9 timeout T=4
    busWrite(5'h0C, cmdWord(16'd4, 0, 1, 1, 1));
    @(negedge clk); // after E1
    for (int i = 0; i < 3; i++) @(negedge clk); // after E4
    peek(5'h08, rv); chk("R9 no error at T", rv, expStat(1, 0, 0));
    @(negedge clk); // after E5
    peek(5'h08, rv); chk("R9 error at T+1", rv, expStat(1, 0, 1));
    chk("R9 port dropped", {31'd0, devOutValid}, 0);
    // R3 command ignored while busy
    busWrite(5'h0C, cmdWord(16'd7, 0, 0, 0, 1));
    peek(5'h0C, rv); chk("R3 cmd ignored busy", rv, cmdWord(16'd4, 0, 1, 1, 1));
    // R10 error clear
    busWrite(5'h0C, cmdWord(16'd0, 1, 0, 0, 0));
    peek(5'h08, rv); chk("R10 cleared", rv, 0);
    chk("R11 irq after clear", {31'd0, irq}, 1);
    @(negedge clk);
    chk("R11 irq drops", {31'd0, irq}, 0);

    // R9 timeout 0 waits
    busWrite(5'h0C, cmdWord(16'd0, 0, 0, 0, 1));
    for (int i = 0; i < 60; i++) @(negedge clk);
    peek(5'h08, rv); chk("R9 zero timeout no error", rv, expStat(1, 0, 0));
    devInValid = 1'b1; devInData = 8'h77; @(negedge clk); devInValid = 1'b0;
    peek(5'h08, rv); chk("R7 ready after long wait", rv, expStat(0, 1, 0));
    busRead(5'h00, rv); chk("R12 din read", rv, 32'h77);

    // R1 odd / high unmapped offsets
    peek(5'h02, rv); chk("R1 unmapped 0x02", rv, 0);
    peek(5'h1C, rv); chk("R1 unmapped 0x1C", rv, 0);

    // random mix
    for (int n = 0; n < 40; n++) begin
      runXfer(1'($urandom), 8'($urandom), 1'($urandom), int'($urandom % 6));
    end

    ended = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule